// File: doc/BRIEF.md
# Converter Start and Capture Controller

This synchronous controller runs a 12-bit subranging analog-to-digital converter from the system clock. While sampling is enabled it raises the converter's start line once per programmed sample period. The high time is a fixed number of clock cycles, chosen at build time so that it lands inside the converter's allowed pulse-width window. The start line also stays low for a minimum number of cycles before each new rise. Only one conversion is ever outstanding. A periodic start that falls due while a conversion is running is held, and it is issued as soon as that conversion has finished.

The converter's data-available strobe arrives without a clock relation. It passes through a two-flop synchronizer and an edge detector. On its rising edge the controller takes in the twelve data bits, the inverted most-significant-bit line and the out-of-range flag. It then formats the word according to a mode input and offers the result to a host with a valid/ready handshake. Over-range and under-range indications come from the range flag together with the true MSB. When the host has not taken the previous sample, a new result is dropped and a saturating overrun counter counts the loss.

Top module: `conv_capture_ctrl`

## Requirements
- R1: After reset the start line, the output valid flag and the overrun counter are all zero.
- R2: Every start pulse is high for exactly ENC_HI clock cycles.
- R3: The start line has been low for at least ENC_LO consecutive cycles before each rise.
- R4: When the converter is idle at each period tick, start pulses rise exactly `period` cycles apart while `run` is high. Dropping `run` stops new starts and discards any held request.
- R5: Only one conversion is outstanding. The start line never rises between a start and the synchronized rising edge of data-available that ends it.
- R6: A tick that arrives during a conversion is held. The next start rises exactly 4 cycles after data-available is seen low at the input, counted from the driving edge.
- R7: The result is taken on the rising edge of data-available. Data, MSB line and range flag presented only after its falling edge do not reach the output.
- R8: Format 2'b10 (two's complement) replaces output bit 11 with the inverted-MSB input. Any other format value (2'b00 straight binary, 2'b01 offset binary, 2'b11) passes all 12 data bits unchanged.
- R9: The range flag at 0 gives over = under = 0. The range flag at 1 with data bit 11 at 1 gives over = 1. The range flag at 1 with data bit 11 at 0 gives under = 1.
- R10: While valid is high and ready is low, the output word and flags hold still. A handshake with no new result clears valid.
- R11: A result that completes while valid is high and ready is low is dropped. The overrun counter then increments and saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables periodic sampling |
| period | input | PER_W | Sample period in clock cycles |
| fmt | input | 2 | Output format select |
| conv_start | output | 1 | Start pulse to the converter |
| conv_dav | input | 1 | Data-available strobe from the converter |
| conv_bits | input | DATA_W | Converter data, bit 11 is the MSB |
| conv_msb_n | input | 1 | Inverted MSB line from the converter |
| conv_range | input | 1 | Out-of-range flag from the converter |
| smp_valid | output | 1 | Sample available to the host |
| smp_ready | input | 1 | Host accepts the sample |
| smp_data | output | DATA_W | Formatted sample |
| smp_over | output | 1 | Sample was above range |
| smp_under | output | 1 | Sample was below range |
| ovr_count | output | OVR_W | Saturating count of dropped samples |

## Verification
A converter model in the bench returns a code sequence that mixes the two extreme codes, both sides of the mid-scale carry, forced over-range and under-range results, and a spread of codes from a multiplicative step. Each pattern runs once in each of the three formats. This separates the MSB substitution from pass-through, and it separates the two range indications from in-range extremes that look alike. The model drives inverted data after each strobe falls, so capturing on the wrong edge shows up as a mismatch. Long and short sample periods tell free-running spacing apart from held requests. A stalled host with more than seven lost results exercises hold-still behaviour, drop counting and saturation.

// File: rtl/conv_capture_ctrl.sv
module conv_capture_ctrl #(
  parameter int DATA_W     = 12,
  parameter int PER_W      = 16,
  parameter int OVR_W      = 8,
  parameter int ENC_HI     = 5,
  parameter int ENC_LO     = 4,
  parameter int CLK_PS     = 5000,
  parameter int HI_MIN_PS  = 20000,
  parameter int HI_MAX_PS  = 30000,
  parameter int LO_MIN_PS  = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PER_W-1:0]  period,
  input  logic [1:0]        fmt,
  output logic              conv_start,
  input  logic              conv_dav,
  input  logic [DATA_W-1:0] conv_bits,
  input  logic              conv_msb_n,
  input  logic              conv_range,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_over,
  output logic              smp_under,
  output logic [OVR_W-1:0]  ovr_count
);

  localparam int HC_W = $clog2(ENC_HI + 1);
  localparam int LC_W = $clog2(ENC_LO + 1);
  localparam logic [1:0] FMT_TWOS = 2'b10;

  if (ENC_HI * CLK_PS < HI_MIN_PS || ENC_HI * CLK_PS > HI_MAX_PS) begin : g_hi_window
    $error("start pulse high time outside the allowed window");
  end
  if (ENC_LO * CLK_PS < LO_MIN_PS) begin : g_lo_window
    $error("start pulse low time below the minimum");
  end

  typedef enum logic [1:0] {S_IDLE, S_HIGH, S_WAIT, S_TAIL} st_t;
  st_t state;

  logic [PER_W-1:0] per_cnt;
  logic [PER_W:0]   per_nxt;
  logic             tick, pending, start;
  logic [HC_W-1:0]  hi_cnt;
  logic [LC_W-1:0]  lo_cnt;
  logic             lo_ok;
  logic             dav_s1, dav_s2, dav_s3, dav_rise;
  logic             cap_fire, slot_free;
  logic [DATA_W-1:0] fmt_word;

  assign per_nxt  = {1'b0, per_cnt} + 1'b1;
  assign tick     = run && (per_nxt >= {1'b0, period});
  assign lo_ok    = lo_cnt >= LC_W'(ENC_LO - 1);
  assign start    = (state == S_IDLE) && pending && lo_ok;
  assign dav_rise = dav_s2 && !dav_s3;
  assign cap_fire = (state == S_WAIT) && dav_rise;
  assign slot_free = !smp_valid || smp_ready;
  assign fmt_word = (fmt == FMT_TWOS) ? {conv_msb_n, conv_bits[DATA_W-2:0]} : conv_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
      pending <= 1'b0;
    end else begin
      per_cnt <= (!run || tick) ? '0 : per_cnt + 1'b1;
      pending <= run && ((pending && !start) || tick);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dav_s1 <= 1'b0;
      dav_s2 <= 1'b0;
      dav_s3 <= 1'b0;
    end else begin
      dav_s1 <= conv_dav;
      dav_s2 <= dav_s1;
      dav_s3 <= dav_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      conv_start <= 1'b0;
      hi_cnt     <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state      <= S_HIGH;
          conv_start <= 1'b1;
          hi_cnt     <= '0;
        end
        S_HIGH: begin
          hi_cnt <= hi_cnt + 1'b1;
          if (hi_cnt == HC_W'(ENC_HI - 1)) begin
            conv_start <= 1'b0;
            state      <= S_WAIT;
          end
        end
        S_WAIT: if (dav_rise) state <= S_TAIL;
        default: if (!dav_s2) state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_cnt <= '0;
    else if (conv_start) lo_cnt <= '0;
    else if (lo_cnt < LC_W'(ENC_LO)) lo_cnt <= lo_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_over  <= 1'b0;
      smp_under <= 1'b0;
      ovr_count <= '0;
    end else if (cap_fire && slot_free) begin
      smp_valid <= 1'b1;
      smp_data  <= fmt_word;
      smp_over  <= conv_range && conv_bits[DATA_W-1];
      smp_under <= conv_range && !conv_bits[DATA_W-1];
    end else if (cap_fire) begin
      if (ovr_count != '1) ovr_count <= ovr_count + 1'b1;
    end else if (smp_ready) begin
      smp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/conv_capture_ctrl_chk.sv
module conv_capture_ctrl_chk #(
  parameter int DATA_W = 12,
  parameter int ENC_HI = 5,
  parameter int ENC_LO = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic              conv_dav,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [DATA_W-1:0] smp_data,
  input logic              smp_over,
  input logic              smp_under
);

  logic [7:0] hcnt, lcnt;
  logic       st_d, d1, d2, d3, busy;
  logic       st_rise, d_rise;

  assign st_rise = conv_start && !st_d;
  assign d_rise  = d2 && !d3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0; lcnt <= '0; st_d <= 1'b0;
      d1 <= 1'b0; d2 <= 1'b0; d3 <= 1'b0; busy <= 1'b0;
    end else begin
      hcnt <= conv_start ? ((hcnt == 8'hff) ? hcnt : hcnt + 1'b1) : 8'd0;
      lcnt <= !conv_start ? ((lcnt == 8'hff) ? lcnt : lcnt + 1'b1) : 8'd0;
      st_d <= conv_start;
      d1 <= conv_dav; d2 <= d1; d3 <= d2;
      if (st_rise) busy <= 1'b1;
      else if (d_rise) busy <= 1'b0;
    end
  end

  // R2
  hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_start) |-> hcnt == 8'(ENC_HI));

  // R2
  hi_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt >= 8'(ENC_HI)) |-> !conv_start);

  // R3
  lo_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_start) |-> lcnt >= 8'(ENC_LO));

  // R5
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_rise |-> !busy);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> smp_valid && $stable(smp_data) && $stable(smp_over) && $stable(smp_under));

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> !(smp_over && smp_under));

endmodule

bind conv_capture_ctrl conv_capture_ctrl_chk #(
  .DATA_W(DATA_W), .ENC_HI(ENC_HI), .ENC_LO(ENC_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_dav(conv_dav),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
  .smp_over(smp_over), .smp_under(smp_under)
);

// File: tb/test_conv_capture_ctrl.sv
`timescale 1ns/1ps
module test_conv_capture_ctrl;
  localparam int ENC_HI = 5, ENC_LO = 4, CONV = 20, DAVW = 16, OVR_W = 3;

  logic clk = 0, rst_n = 0, run = 0, conv_dav = 0, conv_msb_n = 1, conv_range = 0, smp_ready = 1;
  logic [15:0] period = 16'd60;
  logic [1:0] fmt = 2'b00;
  logic [11:0] conv_bits = '0;
  logic conv_start, smp_valid, smp_over, smp_under;
  logic [11:0] smp_data;
  logic [OVR_W-1:0] ovr_count;

  always #2.5 clk = ~clk;

  conv_capture_ctrl #(.OVR_W(OVR_W)) i_conv_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .period(period), .fmt(fmt),
    .conv_start(conv_start), .conv_dav(conv_dav), .conv_bits(conv_bits),
    .conv_msb_n(conv_msb_n), .conv_range(conv_range), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .smp_over(smp_over),
    .smp_under(smp_under), .ovr_count(ovr_count));

  int checks = 0, fails = 0;
  int cyc = 0, conv_k = 0, acc = 0, comps = 0, fall_cyc = 0, last_rise = 0;
  bit sb_on = 1, gapA = 0, gapB = 0, seg_new = 1, outst = 0, ovr_en = 0, st_prev = 0;
  logic [11:0] ovr_code = '0;
  logic [11:0] exp_d [0:511];
  logic exp_o [0:511];
  logic exp_u [0:511];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void code_of(input int k, output logic [11:0] d, output logic o);
    o = 0;
    case (k % 13)
      0: d = 12'h000;
      1: d = 12'hfff;
      2: d = 12'h800;
      3: d = 12'h7ff;
      5: begin d = 12'hfff; o = 1; end
      9: begin d = 12'h000; o = 1; end
      default: d = 12'((k * 157 + 3) & 12'hfff);
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start && !st_prev) begin
        logic [11:0] d; logic o; int k;
        k = conv_k; conv_k++;
        if (ovr_en) begin d = ovr_code; o = 0; end
        else code_of(k, d, o);
        if (sb_on && k < 512) begin
          exp_d[k] = (fmt == 2'b10) ? {~d[11], d[10:0]} : d;
          exp_o[k] = o & d[11];
          exp_u[k] = o & ~d[11];
        end
        repeat (CONV) @(negedge clk);
        conv_bits = d; conv_msb_n = ~d[11]; conv_range = o;
        repeat (4) @(negedge clk);
        conv_dav = 1; comps++; outst = 0;
        repeat (DAVW) @(negedge clk);
        conv_dav = 0; fall_cyc = cyc;
        conv_bits = ~d; conv_msb_n = d[11]; conv_range = ~o;
      end
      st_prev = conv_start;
    end
  end

  // start-line monitor and scoreboard
  initial begin
    bit pv = 0; int hl = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (conv_start && !pv) begin
          chk(!outst, "R5 start while outstanding", 1, 0);
          outst = 1;
          if (gapA && !seg_new) chk(cyc - last_rise == 60, "R4 period spacing", cyc - last_rise, 60);
          if (gapB && !seg_new) chk(cyc - fall_cyc == 4, "R6 held start delay", cyc - fall_cyc, 4);
          seg_new = 0; last_rise = cyc; hl = 0;
        end
        if (conv_start) hl++;
        if (!conv_start && pv) chk(hl == ENC_HI, "R2 high width", hl, ENC_HI);
        if (sb_on && smp_valid && smp_ready) begin
          chk(smp_data == exp_d[acc], "R7 R8 data", smp_data, exp_d[acc]);
          chk({smp_over, smp_under} == {exp_o[acc], exp_u[acc]}, "R9 range flags",
              {smp_over, smp_under}, {exp_o[acc], exp_u[acc]});
          acc++;
        end
      end
      pv = conv_start;
    end
  end

  task automatic segment(input logic [1:0] f, input logic [15:0] p, input int upto, input bit a);
    fmt = f; period = p; seg_new = 1; gapA = a; gapB = !a;
    run = 1;
    while (conv_k < upto) @(negedge clk);
    run = 0; gapA = 0; gapB = 0;
    repeat (200) @(negedge clk);
  endtask

  task automatic sequence_all();
    logic [11:0] v; int c0;
    repeat (5) @(negedge clk);
    chk(conv_start == 0, "R1 start low", conv_start, 0);
    chk(smp_valid == 0, "R1 valid low", smp_valid, 0);
    chk(ovr_count == 0, "R1 overrun zero", ovr_count, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    segment(2'b00, 16'd60, 80, 1);
    segment(2'b01, 16'd8, 160, 0);
    segment(2'b10, 16'd60, 240, 1);
    segment(2'b11, 16'd8, 300, 0);
    segment(2'b10, 16'd8, 360, 0);
    chk(acc == conv_k, "R4 all results delivered", acc, conv_k);
    repeat (300) @(negedge clk);
    chk(conv_start == 0, "R4 no start with run low", conv_start, 0);
    // stall phase
    sb_on = 0; ovr_en = 1; ovr_code = 12'h123; fmt = 2'b00; period = 16'd60;
    smp_ready = 0; run = 1;
    while (!smp_valid) @(negedge clk);
    v = smp_data; c0 = comps; ovr_code = 12'h456;
    while (comps < c0 + 5) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(smp_valid && smp_data == v, "R10 held word", smp_data, v);
    chk(ovr_count == 5, "R11 overrun count", ovr_count, 5);
    while (comps < c0 + 10) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(ovr_count == 7, "R11 saturation", ovr_count, 7);
    chk(smp_valid && smp_data == v, "R10 still held", smp_data, v);
    smp_ready = 1;
    @(negedge clk);
    chk(!smp_valid, "R10 valid clears after handshake", smp_valid, 0);
    while (!smp_valid) @(negedge clk);
    chk(smp_data == 12'h456, "R11 next result after stall", smp_data, 12'h456);
    chk(!smp_over && !smp_under, "R9 in-range flags", {smp_over, smp_under}, 0);
    chk(ovr_count == 7, "R11 count kept", ovr_count, 7);
    run = 0;
    repeat (100) @(negedge clk);
  endtask

  initial begin
    bit timeout = 0;
    fork
      sequence_all();
      begin repeat (150000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule